// File: doc/BRIEF.md
# Steered PWM Output Stage

This block sits after a PWM generator and fans one modulated waveform out to four output pins. Each pin has its own steering enable, so the same waveform can appear on one pin, on several, or on all four at once. A two-bit polarity setting decides whether the steered pins drive active-high or active-low.

A programmable dead-band count holds back the inactive-to-active edge. The active-to-inactive edge is not delayed. An external shutdown input latches a status flag. While that flag is set, the enabled pins are forced to their inactive level. The flag can clear by itself once the shutdown cause goes away, or it can wait for a software clear.

Steering changes are taken in only at period boundaries. After a shutdown, output resumes only at the next period start, so no partial pulse reaches a pin.

Top module: `pwm_steer_out`

## Requirements
- R1: The steering enables are sampled only in a cycle where `period_start` is high, and take effect on the pins from the following cycle. Changes to `steer_en` at any other time have no effect on the pins.
- R2: A pin whose applied steering enable is 0 drives 0 for every polarity setting.
- R3: Polarity works as follows. `pol_sel[0]` sets the polarity of pins 0 and 2, and `pol_sel[1]` sets the polarity of pins 1 and 3. A value of 0 means active-high and 1 means active-low. An enabled pin in normal running drives its active level while the delayed waveform is active, and its inactive level otherwise.
- R4: Take `dly_cnt` = N. Once `pwm_raw` is sampled high, the pins become active at the clock edge that follows N sampled `tick` pulses counted while the raw signal stayed high. With `tick` held high, this is N+1 edges after the first edge that samples the raw signal high. Polarity follows `pol_sel` without delay.
- R5: With N ticks of delay, a raw high pulse that ends before the N ticks are counted produces no active level on any pin.
- R6: If `shut_in` is sampled high, `shut_flag` reads 1 from the next cycle. While the flag is set, enabled pins drive their inactive level and disabled pins drive 0.
- R7: With `auto_restart` = 1, a set flag clears at the first edge that samples `shut_in` low.
- R8: With `auto_restart` = 0, a set flag stays set until an edge samples `sw_clear` high while `shut_in` is low. A `sw_clear` given while `shut_in` is high has no effect.
- R9: After the flag clears, the pins stay inactive until a later `period_start` is sampled. Output resumes in the cycle after that.
- R10: After reset, `shut_flag` is 0, all steering enables are applied as 0, and every pin drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_raw | input | 1 | Modulated waveform from the PWM generator |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| tick | input | 1 | Clock-enable pulse; one dead-band count unit |
| steer_en | input | 4 | Per-pin steering enables (bit i drives pin i) |
| pol_sel | input | 2 | Polarity bits: bit 0 for pins 0/2, bit 1 for pins 1/3, 1 = active-low |
| dly_cnt | input | 7 | Dead-band delay in ticks |
| auto_restart | input | 1 | 1 = flag clears by itself, 0 = software clear needed |
| shut_in | input | 1 | External shutdown request |
| sw_clear | input | 1 | Software clear for the shutdown flag |
| pin_out | output | 4 | Pin drives |
| shut_flag | output | 1 | Shutdown status |

## Verification
The bench builds the block with its default parameters: four pins and a seven-bit delay count. With these values, every combination of the 16 steering patterns and 4 polarity settings can be swept, and every delay count from 0 to 127 can be timed against the arithmetic N+1 edge prediction. The shutdown sequences cover both restart modes, the software clear that arrives during an active shutdown, and the wait for the next period start. Starving the tick and cutting a pulse short show that the delay counts ticks and not clock cycles, and that short pulses are suppressed.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int unsigned NUM_PINS_D = 4;
    localparam int unsigned DLY_W_D    = 7;
    localparam int unsigned POL_W      = 2;

    // polarity selections, bit 0 = pins 0/2 low, bit 1 = pins 1/3 low
    typedef enum logic [POL_W-1:0] {
        POL_ALL_HIGH = 2'b00,
        POL_EVEN_LOW = 2'b01,
        POL_ODD_LOW  = 2'b10,
        POL_ALL_LOW  = 2'b11
    } pol_mode_e;

    typedef struct packed {
        logic act;   // delayed waveform active
        logic run;   // output allowed (armed by period start)
        logic shut;  // shutdown latched
    } gate_state_t;

    function automatic logic waveform_on(input gate_state_t g);
        return g.act & g.run & ~g.shut;
    endfunction

    function automatic logic pin_level(input logic en, input logic on, input logic low);
        return en ? (on ^ low) : 1'b0;
    endfunction

endpackage

// File: rtl/pwm_steer_shadow.sv
module pwm_steer_shadow #(
    parameter int unsigned NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                period_start,
    input  logic [NUM_PINS-1:0] steer_en,
    output logic [NUM_PINS-1:0] steer_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            steer_q <= '0;
        end else if (period_start) begin
            steer_q <= steer_en;
        end
    end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int unsigned DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic [DLY_W-1:0] dly,
    output logic             act_q
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (!raw) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (!act_q) begin
            if (cnt_q >= dly) begin
                act_q <= 1'b1;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_shutdown_latch.sv
module pwm_shutdown_latch (
    input  logic clk,
    input  logic rst,
    input  logic shut_in,
    input  logic sw_clear,
    input  logic auto_restart,
    input  logic period_start,
    output logic shut_q,
    output logic run_q
);
    logic release_ok;

    always_comb begin
        release_ok = !shut_in && (auto_restart || sw_clear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q <= 1'b0;
        end else if (shut_in) begin
            shut_q <= 1'b1;
        end else if (shut_q && release_ok) begin
            shut_q <= 1'b0;
        end
    end

    // re-arm only on a period start seen after the flag is already clear
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (shut_in || shut_q) begin
            run_q <= 1'b0;
        end else if (period_start) begin
            run_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_steer_out.sv
module pwm_steer_out
    import pwm_steer_pkg::*;
#(
    parameter int unsigned NUM_PINS = NUM_PINS_D,
    parameter int unsigned DLY_W    = DLY_W_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwm_raw,
    input  logic                period_start,
    input  logic                tick,
    input  logic [NUM_PINS-1:0] steer_en,
    input  logic [POL_W-1:0]    pol_sel,
    input  logic [DLY_W-1:0]    dly_cnt,
    input  logic                auto_restart,
    input  logic                shut_in,
    input  logic                sw_clear,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                shut_flag
);
    logic [NUM_PINS-1:0] steer_q;
    logic [NUM_PINS-1:0] low_mask;
    logic                act_q;
    logic                run_q;
    logic                shut_q;
    gate_state_t         gs;
    logic                wave_on;

    pwm_steer_shadow #(.NUM_PINS(NUM_PINS)) u_shadow (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .steer_en     (steer_en),
        .steer_q      (steer_q)
    );

    pwm_deadband #(.DLY_W(DLY_W)) u_db (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .raw   (pwm_raw),
        .dly   (dly_cnt),
        .act_q (act_q)
    );

    pwm_shutdown_latch u_sd (
        .clk          (clk),
        .rst          (rst),
        .shut_in      (shut_in),
        .sw_clear     (sw_clear),
        .auto_restart (auto_restart),
        .period_start (period_start),
        .shut_q       (shut_q),
        .run_q        (run_q)
    );

    always_comb begin
        gs.act  = act_q;
        gs.run  = run_q;
        gs.shut = shut_q;
        wave_on = waveform_on(gs);
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign low_mask[i] = pol_sel[i % POL_W];
        assign pin_out[i]  = pin_level(steer_q[i], wave_on, low_mask[i]);
    end

    assign shut_flag = shut_q;
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int unsigned NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                pwm_raw,
    input logic                period_start,
    input logic                auto_restart,
    input logic                shut_in,
    input logic                sw_clear,
    input logic                shut_flag,
    input logic                act_q,
    input logic                run_q,
    input logic [NUM_PINS-1:0] steer_q,
    input logic [NUM_PINS-1:0] low_mask,
    input logic [NUM_PINS-1:0] pin_out
);
    p_shadow_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(steer_q));

    p_fall_now_r4: assert property (@(posedge clk) disable iff (rst)
        !pwm_raw |=> !act_q);

    p_shut_set_r6: assert property (@(posedge clk) disable iff (rst)
        shut_in |=> shut_flag);

    p_safe_level_r6: assert property (@(posedge clk) disable iff (rst)
        shut_flag |-> ((pin_out & ~low_mask) == '0));

    p_auto_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (shut_flag && auto_restart && !shut_in) |=> !shut_flag);

    p_manual_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (shut_flag && !auto_restart && !sw_clear) |=> shut_flag);

    p_clear_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (shut_in && sw_clear) |=> shut_flag);

    p_resume_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(period_start));
endmodule

bind pwm_steer_out pwm_steer_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwm_raw      (pwm_raw),
    .period_start (period_start),
    .auto_restart (auto_restart),
    .shut_in      (shut_in),
    .sw_clear     (sw_clear),
    .shut_flag    (shut_flag),
    .act_q        (act_q),
    .run_q        (run_q),
    .steer_q      (steer_q),
    .low_mask     (low_mask),
    .pin_out      (pin_out)
);

// File: tb/sim_pwm_steer_out.sv
module sim_pwm_steer_out;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_raw = 1'b0;
    logic       period_start = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] steer_en = 4'h0;
    logic [1:0] pol_sel = 2'b00;
    logic [6:0] dly_cnt = 7'd0;
    logic       auto_restart = 1'b0;
    logic       shut_in = 1'b0;
    logic       sw_clear = 1'b0;
    logic [3:0] pin_out;
    logic       shut_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwm_steer_out u0 (
        .clk(clk), .rst(rst), .pwm_raw(pwm_raw), .period_start(period_start),
        .tick(tick), .steer_en(steer_en), .pol_sel(pol_sel), .dly_cnt(dly_cnt),
        .auto_restart(auto_restart), .shut_in(shut_in), .sw_clear(sw_clear),
        .pin_out(pin_out), .shut_flag(shut_flag)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] en);
        steer_en = en;
        period_start = 1'b1;
        cyc();
        period_start = 1'b0;
    endtask

    function automatic logic [3:0] expect_pins(input logic [3:0] en, input logic [1:0] pol,
                                               input logic on);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i] = en[i] ? (on ^ pol[i % 2]) : 1'b0;
        end
        return r;
    endfunction

    initial begin
        while (!finished && cycles < 150000) begin
            @(posedge clk);
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        logic [3:0] hold;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R10 reset state
        check("R10 pins", pin_out, 0);
        check("R10 flag", shut_flag, 0);

        // R1 R2 R3 sweep of enables and polarities
        pwm_raw = 1'b1;
        dly_cnt = 7'd0;
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 16; e++) begin
                pol_sel = p[1:0];
                strobe(e[3:0]);
                check("R3 polarity/steer", pin_out, expect_pins(e[3:0], p[1:0], 1'b1));
                steer_en = ~e[3:0];
                cyc();
                cyc();
                check("R1 ignored mid-period", pin_out, expect_pins(e[3:0], p[1:0], 1'b1));
                check("R2 disabled low", pin_out & ~e[3:0], 0);
            end
        end

        // R4 delay sweep, tick every cycle
        pol_sel = 2'b00;
        strobe(4'hF);
        for (int n = 0; n < 128; n++) begin
            dly_cnt = n[6:0];
            pwm_raw = 1'b0;
            cyc();
            check("R4 fall immediate", pin_out, 0);
            pwm_raw = 1'b1;
            k = 0;
            for (int w = 1; w <= 140; w++) begin
                cyc();
                if (pin_out == 4'hF) begin
                    k = w;
                    break;
                end
            end
            check("R4 rise delay", k, n + 1);
        end

        // R4 delay counts ticks, not cycles
        pwm_raw = 1'b0;
        cyc();
        dly_cnt = 7'd3;
        tick = 1'b0;
        pwm_raw = 1'b1;
        repeat (20) cyc();
        check("R4 no ticks no rise", pin_out, 0);
        tick = 1'b1;
        repeat (3) cyc();
        check("R4 before 3 ticks", pin_out, 0);
        cyc();
        check("R4 after 3 ticks", pin_out, 15);

        // R5 short pulse suppressed
        pwm_raw = 1'b0;
        cyc();
        dly_cnt = 7'd5;
        pwm_raw = 1'b1;
        hold = 4'h0;
        for (int w = 0; w < 4; w++) begin
            cyc();
            hold = hold | pin_out;
        end
        pwm_raw = 1'b0;
        cyc();
        hold = hold | pin_out;
        check("R5 short pulse", hold, 0);

        // R6 shutdown forces inactive level on enabled pins only
        dly_cnt = 7'd0;
        pwm_raw = 1'b1;
        pol_sel = 2'b00;
        auto_restart = 1'b0;
        strobe(4'b0101);
        cyc();
        check("R6 running", pin_out, 5);
        shut_in = 1'b1;
        cyc();
        check("R6 flag set", shut_flag, 1);
        check("R6 inactive high-pol", pin_out, 0);
        pol_sel = 2'b11;
        #1;
        check("R6 inactive low-pol", pin_out, 5);
        pol_sel = 2'b00;

        // R8 manual restart
        sw_clear = 1'b1;
        cyc();
        check("R8 clear blocked", shut_flag, 1);
        sw_clear = 1'b0;
        shut_in = 1'b0;
        repeat (3) cyc();
        check("R8 held", shut_flag, 1);
        sw_clear = 1'b1;
        cyc();
        sw_clear = 1'b0;
        check("R8 cleared", shut_flag, 0);
        repeat (3) cyc();
        check("R9 wait strobe", pin_out, 0);
        strobe(4'b0101);
        check("R9 resumed", pin_out, 5);

        // R7 automatic restart
        auto_restart = 1'b1;
        shut_in = 1'b1;
        repeat (2) cyc();
        check("R7 set", shut_flag, 1);
        shut_in = 1'b0;
        cyc();
        check("R7 auto clear", shut_flag, 0);
        cyc();
        check("R9 inactive after auto", pin_out, 0);
        strobe(4'b1010);
        check("R9 resumed new steer", pin_out, 10);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule